// File: doc/BRIEF.md
# Predicated Register File Writer

This block holds two banks of general-purpose registers, side A and side B, each with sixteen 32-bit entries. It also holds the logic that decides what a write does to them. A write request has four parts: an operation code, a target (side plus index), a 40-bit data word and a predicate selector. The operations are:

- placing a sign-extended 16-bit constant into a register;
- overwriting only the upper half of a register with a 16-bit constant;
- copying a full 32-bit value;
- depositing a 40-bit result across an even/odd register pair.

Any write can be made conditional on one of five fixed condition registers, tested for non-zero or, when inverted, for zero. The predicate is always evaluated against the register contents before the clock edge. A write whose predicate fails changes nothing.

The block is the state-holding back end of a datapath. An upstream decoder presents one write request per cycle. Two combinational read ports expose any register for inspection. They return the contents held before the edge at which a write lands. A one-cycle error flag reports requests that cannot be carried out: a pair write aimed at an odd index, and a write naming an undefined predicate selector.

Top module: `pred_rf_writer`

## Requirements
- R1: While `rst` is high at a clock edge, all 32 registers are cleared to zero and `err` goes low.
- R2: Operation code 1 (constant-low) loads the target with `wr_data[15:0]`, sign-extended to 32 bits. For example, 0xFABC becomes 0xFFFFFABC.
- R3: Operation code 2 (constant-high) replaces bits 31:16 of the target with `wr_data[15:0]` and leaves bits 15:0 as they were. Constant-low followed by constant-high therefore builds an arbitrary 32-bit constant. Constant-high followed by constant-low leaves only the sign-extended low constant.
- R4: Operation code 3 (copy) loads the target with `wr_data[31:0]`.
- R5: `pred_sel` picks the condition: 0 means unconditional (`pred_inv` is ignored), 1 is A1, 2 is A2, 3 is B0, 4 is B1 and 5 is B2. The condition passes when the selected register is non-zero. With `pred_inv` high it passes when that register is zero. The register value used is the one held before the clock edge, even when the write targets that same register.
- R6: A write whose condition fails leaves every register unchanged.
- R7: `pred_sel` values 6 and 7 are undefined. A write (operation codes 1 to 4) carrying one of them is dropped, and `err` is high in the following cycle.
- R8: Operation code 4 (pair) with an even index writes `wr_data[31:0]` to that register. It writes `wr_data[39:32]` into bits 7:0 of the next (odd) register on the same side and clears that register's bits 31:8.
- R9: Operation code 4 with an odd index writes nothing, and `err` is high in the following cycle whatever the predicate.
- R10: Writes take effect at the rising clock edge, and both read ports show the pre-edge value during the cycle of the write. Operation codes 0, 5, 6 and 7 write nothing. `err` is high only in the cycle after an offending request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| wr_op | input | 3 | Write operation code (0 none, 1 constant-low, 2 constant-high, 3 copy, 4 pair) |
| wr_side | input | 1 | Target side, 0 = A, 1 = B |
| wr_idx | input | 4 | Target register index |
| wr_data | input | 40 | Write data; constants use bits 15:0, copy bits 31:0, pair all 40 |
| pred_sel | input | 3 | Condition register selector |
| pred_inv | input | 1 | Invert the condition (pass on zero) |
| err | output | 1 | Rejected request in the previous cycle |
| rd0_side | input | 1 | Read port 0 side |
| rd0_idx | input | 4 | Read port 0 index |
| rd0_data | output | 32 | Read port 0 data |
| rd1_side | input | 1 | Read port 1 side |
| rd1_idx | input | 4 | Read port 1 index |
| rd1_data | output | 32 | Read port 1 data |

## Verification
The bench aims at the ordering of constant halves. A design that zeroes or sign-fills the low half on a high-half write, or leaves stale upper bits on a low-half write, shows a wrong value in the register after the second half lands. Predicates are tested on every condition register, in both polarities, and when the write targets the condition register itself. A design that picks the wrong register, flips the polarity, or reads the condition after the write lets a suppressed value leak through or drops a valid one. Pair writes are run with a non-zero odd register beforehand, which exposes a missing clear of bits 31:8. Odd and reserved-selector requests are followed straight away by reads of neighbouring registers and of `err`, so a design that writes a rejected pair or mistimes the flag is caught.

// File: rtl/pred_rf_pkg.sv
package pred_rf_pkg;

    localparam int unsigned NREG  = 16;
    localparam int unsigned DW    = 32;
    localparam int unsigned XW    = 40;
    localparam int unsigned CW    = 16;
    localparam int unsigned NSIDE = 2;
    localparam int unsigned NCOND = 5;
    localparam int unsigned IW    = $clog2(NREG);
    localparam int unsigned EW    = XW - DW;

    typedef enum logic [2:0] {
        OP_IDLE  = 3'd0,
        OP_SETLO = 3'd1,
        OP_SETHI = 3'd2,
        OP_COPY  = 3'd3,
        OP_WIDE  = 3'd4
    } wop_e;

    typedef enum logic [2:0] {
        PS_ALWAYS = 3'd0,
        PS_A1     = 3'd1,
        PS_A2     = 3'd2,
        PS_B0     = 3'd3,
        PS_B1     = 3'd4,
        PS_B2     = 3'd5
    } psel_e;

    typedef struct packed {
        logic          en;
        logic          side;
        logic [IW-1:0] idx;
        logic [DW-1:0] val;
    } wlane_t;

    function automatic logic [DW-1:0] sext_const(input logic [CW-1:0] k);
        return {{(DW-CW){k[CW-1]}}, k};
    endfunction

    function automatic logic is_write_op(input logic [2:0] op);
        return (op == OP_SETLO) || (op == OP_SETHI) ||
               (op == OP_COPY)  || (op == OP_WIDE);
    endfunction

endpackage

// File: rtl/pred_rf_cond.sv
module pred_rf_cond
    import pred_rf_pkg::*;
(
    input  logic [NCOND-1:0][DW-1:0] cands,
    input  logic [2:0]               sel,
    input  logic                     inv,
    output logic                     pass,
    output logic                     bad_sel
);
    logic nz;

    always_comb begin
        nz      = 1'b0;
        bad_sel = 1'b0;
        case (sel)
            PS_ALWAYS: nz = 1'b1;
            PS_A1:     nz = |cands[0];
            PS_A2:     nz = |cands[1];
            PS_B0:     nz = |cands[2];
            PS_B1:     nz = |cands[3];
            PS_B2:     nz = |cands[4];
            default:   bad_sel = 1'b1;
        endcase
        if (bad_sel)
            pass = 1'b0;
        else if (sel == PS_ALWAYS)
            pass = 1'b1;
        else
            pass = nz ^ inv;
    end
endmodule

// File: rtl/pred_rf_wrgen.sv
module pred_rf_wrgen
    import pred_rf_pkg::*;
(
    input  logic [2:0]    op,
    input  logic          side,
    input  logic [IW-1:0] idx,
    input  logic [XW-1:0] data,
    input  logic [CW-1:0] old_lo,
    input  logic          pass,
    input  logic          bad_sel,
    output wlane_t        lane0,
    output wlane_t        lane1,
    output logic          err_now
);
    logic odd_pair;

    always_comb begin
        lane0    = '0;
        lane1    = '0;
        odd_pair = 1'b0;
        lane0.side = side;
        lane0.idx  = idx;
        lane1.side = side;
        lane1.idx  = {idx[IW-1:1], 1'b1};
        case (op)
            OP_SETLO: begin
                lane0.en  = pass;
                lane0.val = sext_const(data[CW-1:0]);
            end
            OP_SETHI: begin
                lane0.en  = pass;
                lane0.val = {data[CW-1:0], old_lo};
            end
            OP_COPY: begin
                lane0.en  = pass;
                lane0.val = data[DW-1:0];
            end
            OP_WIDE: begin
                if (idx[0]) begin
                    odd_pair = 1'b1;
                end else begin
                    lane0.en  = pass;
                    lane0.val = data[DW-1:0];
                    lane1.en  = pass;
                    lane1.val = {{(DW-EW){1'b0}}, data[XW-1:DW]};
                end
            end
            default: ;
        endcase
        err_now = odd_pair | (is_write_op(op) & bad_sel);
    end
endmodule

// File: rtl/pred_rf_bank.sv
module pred_rf_bank
    import pred_rf_pkg::*;
#(
    parameter bit SIDE = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  wlane_t                  lane0,
    input  wlane_t                  lane1,
    output logic [NREG-1:0][DW-1:0] regs_o
);
    for (genvar i = 0; i < NREG; i++) begin : g_reg
        logic [DW-1:0] q;
        logic          hit0;
        logic          hit1;

        assign hit0 = lane0.en && (lane0.side == SIDE) && (lane0.idx == IW'(i));
        assign hit1 = lane1.en && (lane1.side == SIDE) && (lane1.idx == IW'(i));

        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (hit0)
                q <= lane0.val;
            else if (hit1)
                q <= lane1.val;
        end

        assign regs_o[i] = q;
    end
endmodule

// File: rtl/pred_rf_writer.sv
module pred_rf_writer
    import pred_rf_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [2:0]    wr_op,
    input  logic          wr_side,
    input  logic [IW-1:0] wr_idx,
    input  logic [XW-1:0] wr_data,
    input  logic [2:0]    pred_sel,
    input  logic          pred_inv,
    output logic          err,
    input  logic          rd0_side,
    input  logic [IW-1:0] rd0_idx,
    output logic [DW-1:0] rd0_data,
    input  logic          rd1_side,
    input  logic [IW-1:0] rd1_idx,
    output logic [DW-1:0] rd1_data
);
    logic [NSIDE-1:0][NREG-1:0][DW-1:0] rf;
    logic [NCOND-1:0][DW-1:0]           cands;
    logic [DW-1:0]                      tgt_old;
    wlane_t                             lane0;
    wlane_t                             lane1;
    logic                               pass;
    logic                               bad_sel;
    logic                               err_now;
    logic                               err_q;

    assign cands = {rf[1][2], rf[1][1], rf[1][0], rf[0][2], rf[0][1]};
    assign tgt_old = rf[wr_side][wr_idx];

    pred_rf_cond u_cond (
        .cands   (cands),
        .sel     (pred_sel),
        .inv     (pred_inv),
        .pass    (pass),
        .bad_sel (bad_sel)
    );

    pred_rf_wrgen u_wrgen (
        .op      (wr_op),
        .side    (wr_side),
        .idx     (wr_idx),
        .data    (wr_data),
        .old_lo  (tgt_old[CW-1:0]),
        .pass    (pass),
        .bad_sel (bad_sel),
        .lane0   (lane0),
        .lane1   (lane1),
        .err_now (err_now)
    );

    for (genvar s = 0; s < NSIDE; s++) begin : g_side
        pred_rf_bank #(.SIDE(s[0])) u_bank (
            .clk    (clk),
            .rst    (rst),
            .lane0  (lane0),
            .lane1  (lane1),
            .regs_o (rf[s])
        );
    end

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= 1'b0;
        else
            err_q <= err_now;
    end

    assign err      = err_q;
    assign rd0_data = rf[rd0_side][rd0_idx];
    assign rd1_data = rf[rd1_side][rd1_idx];
endmodule

// File: rtl/pred_rf_checker.sv
module pred_rf_checker
    import pred_rf_pkg::*;
(
    input logic                               clk,
    input logic                               rst,
    input logic [2:0]                         wr_op,
    input logic                               wr_side,
    input logic [IW-1:0]                      wr_idx,
    input logic [XW-1:0]                      wr_data,
    input logic [2:0]                         pred_sel,
    input logic                               pred_inv,
    input logic                               err,
    input logic [NSIDE-1:0][NREG-1:0][DW-1:0] rf
);
    logic          ok;
    logic          last_side;
    logic [IW-1:0] last_idx;
    logic [DW-1:0] tgt_now;
    logic [DW-1:0] tgt_then;
    logic [DW-1:0] pair_then;

    always_comb begin
        case (pred_sel)
            3'd0:    ok = 1'b1;
            3'd1:    ok = (rf[0][1] != '0) ^ pred_inv;
            3'd2:    ok = (rf[0][2] != '0) ^ pred_inv;
            3'd3:    ok = (rf[1][0] != '0) ^ pred_inv;
            3'd4:    ok = (rf[1][1] != '0) ^ pred_inv;
            3'd5:    ok = (rf[1][2] != '0) ^ pred_inv;
            default: ok = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            last_side <= 1'b0;
            last_idx  <= '0;
        end else begin
            last_side <= wr_side;
            last_idx  <= wr_idx;
        end
    end

    assign tgt_now   = rf[wr_side][wr_idx];
    assign tgt_then  = rf[last_side][last_idx];
    assign pair_then = rf[last_side][{last_idx[IW-1:1], 1'b1}];

    assert_reset_err_R1: assert property (@(posedge clk) rst |=> !err);

    assert_lo_sext_R2: assert property (@(posedge clk) disable iff (rst)
        (wr_op == 3'd1 && ok) |=>
        tgt_then == {{(DW-CW){$past(wr_data[CW-1])}}, $past(wr_data[CW-1:0])});

    assert_hi_keep_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_op == 3'd2 && ok) |=>
        (tgt_then[CW-1:0] == $past(tgt_now[CW-1:0])) &&
        (tgt_then[DW-1:CW] == $past(wr_data[CW-1:0])));

    assert_copy_R4: assert property (@(posedge clk) disable iff (rst)
        (wr_op == 3'd3 && ok) |=> tgt_then == $past(wr_data[DW-1:0]));

    assert_suppress_R6: assert property (@(posedge clk) disable iff (rst)
        (wr_op >= 3'd1 && wr_op <= 3'd3 && !ok) |=> tgt_then == $past(tgt_now));

    assert_bad_sel_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_op >= 3'd1 && wr_op <= 3'd4 && pred_sel >= 3'd6) |=> err);

    assert_pair_hi_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_op == 3'd4 && !wr_idx[0] && ok) |=>
        pair_then == {{(DW-EW){1'b0}}, $past(wr_data[XW-1:DW])});

    assert_odd_pair_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_op == 3'd4 && wr_idx[0]) |=> err && tgt_then == $past(tgt_now));

    assert_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (wr_op == 3'd0 || wr_op >= 3'd5) |=> !err && tgt_then == $past(tgt_now));
endmodule

bind pred_rf_writer pred_rf_checker u_chk (
    .clk      (clk),
    .rst      (rst),
    .wr_op    (wr_op),
    .wr_side  (wr_side),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data),
    .pred_sel (pred_sel),
    .pred_inv (pred_inv),
    .err      (err),
    .rf       (rf)
);

// File: tb/test_pred_rf_writer.sv
`timescale 1ns/1ps
module test_pred_rf_writer;

    logic        clk = 1'b0;
    logic        rst;
    logic [2:0]  wr_op;
    logic        wr_side;
    logic [3:0]  wr_idx;
    logic [39:0] wr_data;
    logic [2:0]  pred_sel;
    logic        pred_inv;
    logic        err;
    logic        rd0_side;
    logic [3:0]  rd0_idx;
    logic [31:0] rd0_data;
    logic        rd1_side;
    logic [3:0]  rd1_idx;
    logic [31:0] rd1_data;

    always #10 clk = ~clk;

    pred_rf_writer i_pred_rf_writer (
        .clk(clk), .rst(rst), .wr_op(wr_op), .wr_side(wr_side), .wr_idx(wr_idx),
        .wr_data(wr_data), .pred_sel(pred_sel), .pred_inv(pred_inv), .err(err),
        .rd0_side(rd0_side), .rd0_idx(rd0_idx), .rd0_data(rd0_data),
        .rd1_side(rd1_side), .rd1_idx(rd1_idx), .rd1_data(rd1_data)
    );

    logic [31:0] mdl [2][16];
    int          vec = 0;
    int          bad = 0;
    bit          done = 0;
    bit          exp_err = 0;
    bit          prev_side = 0;
    logic [3:0]  prev_idx = 0;
    string       prev_tag = "R1";

    task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
        vec++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    function automatic bit cond_pass(logic [2:0] ps, bit inv);
        case (ps)
            3'd0: return 1'b1;
            3'd1: return (mdl[0][1] != 0) ^ inv;
            3'd2: return (mdl[0][2] != 0) ^ inv;
            3'd3: return (mdl[1][0] != 0) ^ inv;
            3'd4: return (mdl[1][1] != 0) ^ inv;
            3'd5: return (mdl[1][2] != 0) ^ inv;
            default: return 1'b0;
        endcase
    endfunction

    task automatic apply(string tag_in, logic [2:0] op, bit side, logic [3:0] idx,
                         logic [39:0] d, logic [2:0] ps, bit inv);
        string       tag;
        bit          wr;
        bit          ok;
        bit          oddp;
        bit          new_err;
        logic [31:0] nv;
        @(negedge clk);
        wr_op = op; wr_side = side; wr_idx = idx; wr_data = d;
        pred_sel = ps; pred_inv = inv;
        rd0_side = side; rd0_idx = idx;
        rd1_side = prev_side; rd1_idx = prev_idx;
        #1;
        wr   = (op >= 3'd1 && op <= 3'd4);
        ok   = cond_pass(ps, inv);
        oddp = (op == 3'd4) && idx[0];
        if (tag_in != "") tag = tag_in;
        else if (wr && ps >= 3'd6) tag = "R7";
        else if (oddp) tag = "R9";
        else if (wr && !ok) tag = "R6";
        else if (wr && ps != 3'd0) tag = "R5";
        else case (op)
            3'd1: tag = "R2";
            3'd2: tag = "R3";
            3'd3: tag = "R4";
            3'd4: tag = "R8";
            default: tag = "R10";
        endcase
        // R10: pre-edge value visible on the read port
        chk("R10 read before write", rd0_data, mdl[side][idx]);
        chk({prev_tag, " result readback"}, rd1_data, mdl[prev_side][prev_idx]);
        chk({prev_tag, " err"}, {31'd0, err}, {31'd0, exp_err});
        new_err = wr && (ps >= 3'd6 || oddp);
        @(posedge clk);
        if (wr && ok && !oddp) begin
            case (op)
                3'd1: nv = {{16{d[15]}}, d[15:0]};
                3'd2: nv = {d[15:0], mdl[side][idx][15:0]};
                3'd3: nv = d[31:0];
                default: nv = d[31:0];
            endcase
            mdl[side][idx] = nv;
            if (op == 3'd4) mdl[side][{idx[3:1], 1'b1}] = {24'd0, d[39:32]};
        end
        exp_err   = new_err;
        prev_side = side;
        prev_idx  = idx;
        prev_tag  = tag;
    endtask

    task automatic sweep(string tag);
        for (int k = 0; k < 32; k++)
            apply(tag, 3'd0, k[4], k[3:0], 40'd0, 3'd0, 1'b0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            $display("FAIL R10 watchdog: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2; s++)
            for (int r = 0; r < 16; r++) mdl[s][r] = 32'd0;
        rst = 1'b1; wr_op = 0; wr_side = 0; wr_idx = 0; wr_data = 0;
        pred_sel = 0; pred_inv = 0; rd0_side = 0; rd0_idx = 0; rd1_side = 0; rd1_idx = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1: reset state of all registers and flag
        sweep("R1");
        // R2 / R3: constant halves in both orders
        apply("", 3'd1, 0, 4'd5, 40'h0FABC, 3'd0, 0);
        apply("", 3'd2, 0, 4'd5, 40'h01234, 3'd0, 0);
        apply("", 3'd1, 0, 4'd6, 40'h04321, 3'd0, 0);
        apply("", 3'd2, 0, 4'd7, 40'h01234, 3'd0, 0);
        apply("", 3'd1, 0, 4'd7, 40'h0FABC, 3'd0, 0);
        // R4: copy
        apply("", 3'd3, 1, 4'd3, 40'hFF_DEADBEEF, 3'd0, 0);
        // R5 / R6: predicate on A1 in both polarities
        apply("", 3'd3, 0, 4'd3, 40'h11111111, 3'd1, 0);
        apply("", 3'd3, 0, 4'd3, 40'h22222222, 3'd1, 1);
        apply("", 3'd3, 0, 4'd1, 40'h5, 3'd0, 0);
        apply("", 3'd3, 0, 4'd3, 40'h33333333, 3'd1, 0);
        apply("", 3'd3, 0, 4'd3, 40'h44444444, 3'd1, 1);
        // R5: self-targeting predicate uses pre-edge value
        apply("", 3'd3, 0, 4'd1, 40'h0, 3'd1, 0);
        apply("", 3'd3, 0, 4'd1, 40'h9, 3'd1, 0);
        apply("", 3'd3, 0, 4'd1, 40'h7, 3'd1, 1);
        for (int ps = 2; ps <= 5; ps++)
            for (int iv = 0; iv < 2; iv++)
                apply("", 3'd3, 1, 4'd9, 40'(ps * 16 + iv), 3'(ps), iv[0]);
        apply("", 3'd3, 1, 4'd1, 40'hAB, 3'd0, 0);
        for (int ps = 2; ps <= 5; ps++)
            for (int iv = 0; iv < 2; iv++)
                apply("", 3'd1, 1, 4'd10, 40'(ps * 256 + iv), 3'(ps), iv[0]);
        // R7: undefined selectors
        apply("", 3'd3, 0, 4'd8, 40'h1234, 3'd6, 0);
        apply("", 3'd2, 0, 4'd8, 40'h1234, 3'd7, 1);
        // R8: pair write onto a non-zero odd register
        apply("", 3'd3, 0, 4'd5, 40'hFFFFFFFF, 3'd0, 0);
        apply("", 3'd4, 0, 4'd4, 40'hAB_12345678, 3'd0, 0);
        apply("R8 odd half", 3'd0, 0, 4'd5, 40'd0, 3'd0, 0);
        apply("", 3'd4, 1, 4'd14, 40'h7F_CAFEF00D, 3'd0, 0);
        apply("R8 odd half", 3'd0, 1, 4'd15, 40'd0, 3'd0, 0);
        // R9: odd base rejected
        apply("", 3'd4, 1, 4'd1, 40'h55_66666666, 3'd0, 0);
        apply("R9 neighbour", 3'd0, 1, 4'd0, 40'd0, 3'd0, 0);
        apply("", 3'd4, 1, 4'd3, 40'h55_66666666, 3'd1, 1);
        // R6: failed predicate on a pair
        apply("", 3'd4, 0, 4'd12, 40'h99_88888888, 3'd2, 0);
        apply("R6 pair odd half", 3'd0, 0, 4'd13, 40'd0, 3'd0, 0);
        // R10: idle and unused operation codes
        for (int op = 5; op < 8; op++)
            apply("", 3'(op), 0, 4'd4, 40'hFF_FFFFFFFF, 3'd0, 0);
        apply("", 3'd0, 0, 4'd4, 40'hFF_FFFFFFFF, 3'd0, 0);
        for (int n = 0; n < 400; n++)
            apply("", 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
                  4'($urandom_range(0, 15)), {8'($urandom), 32'($urandom)},
                  3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)));
        sweep("R10 final");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end
endmodule